// File: doc/BRIEF.md
# Floating-Point Status and Rounding Control Register

This block is the control-and-status register that sits beside a single-precision floating-point datapath. It keeps two fields: five sticky exception flags and a three-bit dynamic rounding mode. On every cycle it turns the rounding field of the instruction being issued into the rounding mode the datapath must use. Code 7 in that field means "use the stored dynamic mode". Any result that ends up on a reserved code is reported as an illegal instruction.

When the datapath finishes an operation, it presents the operation class and the five exception bits it raised. For classes that are defined to report exceptions, the block ORs those bits into the accrued flags. The other classes leave the flags alone: sign injection, moves between register files, memory transfers and classification. A simple access port reads and writes the register through three views: the whole register, the flags only, and the rounding mode only. The block has no state machine. Its behaviour is two registers with a fixed update priority, and writes from the access port take precedence over flag merging.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, the flag field and the dynamic rounding mode are both zero. Zero is the round-to-nearest-even code, so a full-view read returns 0.
- R2: When the instruction rounding field is 0 to 6, `eff_rm` equals that field.
- R3: When the instruction rounding field is 7, `eff_rm` equals the stored dynamic rounding mode.
- R4: `rm_illegal` is high exactly when `eff_rm` is 5, 6 or 7.
- R5: A completing operation merges its flags when `done_valid` is high and `done_class` is 0 to 11. Those class codes are add, sub, mul, div, sqrt, the four fused multiply-add forms, min/max, compare and float-to-integer. The merge ORs `done_flags` into the flags on the next edge, so set flags stay set.
- R6: Classes 12 to 15 leave the flags unchanged, even when `done_flags` is nonzero. Those codes are sign injection, register move, load/store and classify.
- R7: View 0 (full) reads {24'b0, rm[2:0], flags[4:0]}. Writing view 0 loads flags from wdata[4:0] and the rounding mode from wdata[7:5]. Bits 31:8 are ignored.
- R8: View 1 (flags) reads {27'b0, flags}. Writing view 1 loads only the flags from wdata[4:0] and leaves the rounding mode unchanged.
- R9: View 2 (rounding mode) reads {29'b0, rm}. Writing view 2 loads only the rounding mode from wdata[2:0] and leaves the flags unchanged.
- R10: View 3 reads zero, and a write to view 3 changes nothing.
- R11: If a write to view 0 or 1 and a flag merge occur in the same cycle, the written value wins and the merge is dropped. A view-2 write in the same cycle does not block the merge.
- R12: With `done_valid` low and no write, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_rm | input | 3 | Rounding field of the issuing instruction |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is a reserved code |
| done_valid | input | 1 | An operation completes this cycle |
| done_class | input | 4 | Class of the completing operation |
| done_flags | input | 5 | Exception bits raised by that operation |
| csr_we | input | 1 | Access-port write strobe |
| csr_view | input | 2 | Access view: 0 full, 1 flags, 2 rounding mode, 3 none |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected view (combinational) |

## Verification
The bench builds the block with its defaults: a 4-bit class code, a flag-producing class mask of 0x0FFF and 32-bit access data. With these values, all sixteen classes and all eight instruction rounding codes can be reached. Random traffic therefore mixes merging and non-merging classes with every view and every reserved-mode path. Directed cases cover write-versus-merge collisions on each view, a reserved stored mode selected through code 7, and upper write bits that must be ignored.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'd0,
        VIEW_FLAGS = 2'd1,
        VIEW_RMODE = 2'd2,
        VIEW_NONE  = 2'd3
    } csr_view_e;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4,
        RM_RSVD5     = 3'd5,
        RM_RSVD6     = 3'd6,
        RM_USE_DYN   = 3'd7
    } rmode_e;

endpackage

// File: rtl/fp_rm_resolve.sv
module fp_rm_resolve #(
    parameter int RM_W      = 3,
    parameter int RSVD_FROM = 5
) (
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            illegal
);
    localparam logic [RM_W-1:0] DYN_CODE = '1;
    localparam logic [RM_W-1:0] RSVD_LO  = RM_W'(RSVD_FROM);

    always_comb begin
        eff_rm  = (insn_rm == DYN_CODE) ? dyn_rm : insn_rm;
        illegal = (eff_rm >= RSVD_LO);
    end
endmodule

// File: rtl/fp_flag_merge.sv
module fp_flag_merge #(
    parameter int                    CLS_W      = 4,
    parameter int                    FLAG_W     = 5,
    parameter logic [(1<<CLS_W)-1:0] CLASS_MASK = '1
) (
    input  logic              done_valid,
    input  logic [CLS_W-1:0]  done_class,
    input  logic [FLAG_W-1:0] done_flags,
    output logic              merge_en,
    output logic [FLAG_W-1:0] merge_bits
);
    localparam int N_CLS = 1 << CLS_W;

    logic [N_CLS-1:0] cls_hit;

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        if (CLASS_MASK[c]) begin : g_on
            assign cls_hit[c] = (done_class == CLS_W'(c));
        end else begin : g_off
            assign cls_hit[c] = 1'b0;
        end
    end

    always_comb begin
        merge_en   = done_valid && (|cls_hit);
        merge_bits = done_flags;
    end
endmodule

// File: rtl/fp_csr_port.sv
module fp_csr_port
    import fp_status_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3
) (
    input  logic              csr_we,
    input  logic [1:0]        csr_view,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [FLAG_W-1:0] flags_q,
    input  logic [RM_W-1:0]   rm_q,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              wr_flags,
    output logic              wr_rm,
    output logic [FLAG_W-1:0] flags_wval,
    output logic [RM_W-1:0]   rm_wval
);
    localparam int REG_W = FLAG_W + RM_W;

    csr_view_e view;
    logic      unused_hi;

    assign view      = csr_view_e'(csr_view);
    assign unused_hi = ^csr_wdata[XLEN-1:REG_W];

    always_comb begin
        csr_rdata  = '0;
        wr_flags   = 1'b0;
        wr_rm      = 1'b0;
        flags_wval = csr_wdata[FLAG_W-1:0];
        rm_wval    = csr_wdata[RM_W-1:0];
        unique case (view)
            VIEW_FULL: begin
                csr_rdata = {{(XLEN-REG_W){1'b0}}, rm_q, flags_q};
                wr_flags  = csr_we;
                wr_rm     = csr_we;
                rm_wval   = csr_wdata[REG_W-1:FLAG_W];
            end
            VIEW_FLAGS: begin
                csr_rdata = {{(XLEN-FLAG_W){1'b0}}, flags_q};
                wr_flags  = csr_we;
            end
            VIEW_RMODE: begin
                csr_rdata = {{(XLEN-RM_W){1'b0}}, rm_q};
                wr_rm     = csr_we;
            end
            VIEW_NONE: begin
                csr_rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl #(
    parameter int                    XLEN       = 32,
    parameter int                    FLAG_W     = 5,
    parameter int                    RM_W       = 3,
    parameter int                    CLS_W      = 4,
    parameter logic [(1<<CLS_W)-1:0] CLASS_MASK = 16'h0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RM_W-1:0]   insn_rm,
    output logic [RM_W-1:0]   eff_rm,
    output logic              rm_illegal,
    input  logic              done_valid,
    input  logic [CLS_W-1:0]  done_class,
    input  logic [FLAG_W-1:0] done_flags,
    input  logic              csr_we,
    input  logic [1:0]        csr_view,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata
);
    logic [FLAG_W-1:0] flags_q;
    logic [RM_W-1:0]   rm_q;
    logic              merge_en;
    logic [FLAG_W-1:0] merge_bits;
    logic              wr_flags;
    logic              wr_rm;
    logic [FLAG_W-1:0] flags_wval;
    logic [RM_W-1:0]   rm_wval;

    fp_rm_resolve #(.RM_W(RM_W), .RSVD_FROM(5)) i_rm_resolve (
        .insn_rm (insn_rm),
        .dyn_rm  (rm_q),
        .eff_rm  (eff_rm),
        .illegal (rm_illegal)
    );

    fp_flag_merge #(.CLS_W(CLS_W), .FLAG_W(FLAG_W), .CLASS_MASK(CLASS_MASK)) i_flag_merge (
        .done_valid (done_valid),
        .done_class (done_class),
        .done_flags (done_flags),
        .merge_en   (merge_en),
        .merge_bits (merge_bits)
    );

    fp_csr_port #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) i_csr_port (
        .csr_we     (csr_we),
        .csr_view   (csr_view),
        .csr_wdata  (csr_wdata),
        .flags_q    (flags_q),
        .rm_q       (rm_q),
        .csr_rdata  (csr_rdata),
        .wr_flags   (wr_flags),
        .wr_rm      (wr_rm),
        .flags_wval (flags_wval),
        .rm_wval    (rm_wval)
    );

    // Access-port write wins over a merge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            rm_q    <= '0;
        end else begin
            if (wr_flags) begin
                flags_q <= flags_wval;
            end else if (merge_en) begin
                flags_q <= flags_q | merge_bits;
            end
            if (wr_rm) begin
                rm_q <= rm_wval;
            end
        end
    end
endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk #(
    parameter int                    XLEN       = 32,
    parameter int                    FLAG_W     = 5,
    parameter int                    RM_W       = 3,
    parameter int                    CLS_W      = 4,
    parameter logic [(1<<CLS_W)-1:0] CLASS_MASK = 16'h0FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RM_W-1:0]   insn_rm,
    input logic [RM_W-1:0]   eff_rm,
    input logic              rm_illegal,
    input logic              done_valid,
    input logic [CLS_W-1:0]  done_class,
    input logic [FLAG_W-1:0] done_flags,
    input logic              csr_we,
    input logic [1:0]        csr_view,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [XLEN-1:0]   csr_rdata,
    input logic [FLAG_W-1:0] flags_q,
    input logic [RM_W-1:0]   rm_q
);
    localparam int REG_W = FLAG_W + RM_W;

    logic flag_wr;
    logic cls_on;
    assign flag_wr = csr_we && (csr_view == 2'd0 || csr_view == 2'd1);
    assign cls_on  = CLASS_MASK[done_class];

    a_r2_direct_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm != '1) |-> (eff_rm == insn_rm));

    a_r3_dynamic_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm == '1) |-> (eff_rm == rm_q));

    a_r4_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rm_illegal == (eff_rm >= RM_W'(5)));

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    a_r5_merge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && done_valid && cls_on) |=> ((flags_q & $past(done_flags)) == $past(done_flags)));

    a_r6_no_merge_class: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && !(done_valid && cls_on)) |=> $stable(flags_q));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_view == 2'd0) |-> (csr_rdata[XLEN-1:REG_W] == '0));

    a_r10_view_none: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_view == 2'd3) |-> (csr_rdata == '0));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (flags_q == $past(csr_wdata[FLAG_W-1:0])));
endmodule

bind fp_status_ctrl fp_status_ctrl_chk #(
    .XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W), .CLS_W(CLS_W), .CLASS_MASK(CLASS_MASK)
) i_fp_status_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_rm    (insn_rm),
    .eff_rm     (eff_rm),
    .rm_illegal (rm_illegal),
    .done_valid (done_valid),
    .done_class (done_class),
    .done_flags (done_flags),
    .csr_we     (csr_we),
    .csr_view   (csr_view),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .flags_q    (flags_q),
    .rm_q       (rm_q)
);

// File: tb/test_fp_status_ctrl.sv
module test_fp_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  insn_rm = '0;
    logic [2:0]  eff_rm;
    logic        rm_illegal;
    logic        done_valid = 1'b0;
    logic [3:0]  done_class = '0;
    logic [4:0]  done_flags = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_view = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [4:0] m_flags = '0;
    logic [2:0] m_rm = '0;

    always #10 clk = ~clk;

    fp_status_ctrl i_fp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .insn_rm(insn_rm), .eff_rm(eff_rm),
        .rm_illegal(rm_illegal), .done_valid(done_valid), .done_class(done_class),
        .done_flags(done_flags), .csr_we(csr_we), .csr_view(csr_view),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] v);
        case (v)
            2'd0:    return {24'b0, m_rm, m_flags};
            2'd1:    return {27'b0, m_flags};
            2'd2:    return {29'b0, m_rm};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [2:0] exp_eff(input logic [2:0] f);
        return (f == 3'd7) ? m_rm : f;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Checks combinational outputs against the model, then clocks one edge and updates the model.
    task automatic cycle(input logic [2:0] rmf, input logic dv, input logic [3:0] cls,
                         input logic [4:0] fl, input logic we, input logic [1:0] vw,
                         input logic [31:0] wd);
        logic [2:0] e;
        @(negedge clk);
        insn_rm = rmf; done_valid = dv; done_class = cls; done_flags = fl;
        csr_we = we; csr_view = vw; csr_wdata = wd;
        #1;
        e = exp_eff(rmf);
        if (rmf != 3'd7) check(eff_rm == e, "R2 eff_rm", 32'(eff_rm), 32'(e));
        else             check(eff_rm == e, "R3 eff_rm", 32'(eff_rm), 32'(e));
        check(rm_illegal == (e >= 3'd5), "R4 rm_illegal", 32'(rm_illegal), 32'(e >= 3'd5));
        case (vw)
            2'd0: check(csr_rdata == exp_read(vw), "R7 full read", csr_rdata, exp_read(vw));
            2'd1: check(csr_rdata == exp_read(vw), "R8 flags read", csr_rdata, exp_read(vw));
            2'd2: check(csr_rdata == exp_read(vw), "R9 rm read", csr_rdata, exp_read(vw));
            default: check(csr_rdata == 32'b0, "R10 none read", csr_rdata, 32'b0);
        endcase
        @(posedge clk);
        if (we && vw == 2'd0) begin
            m_flags = wd[4:0]; m_rm = wd[7:5];
        end else if (we && vw == 2'd1) begin
            m_flags = wd[4:0];
        end else if (dv && cls <= 4'd11) begin
            m_flags = m_flags | fl;
        end
        if (we && vw == 2'd2) m_rm = wd[2:0];
    endtask

    task automatic read_check(input logic [1:0] vw, input string tag);
        @(negedge clk);
        done_valid = 1'b0; csr_we = 1'b0; csr_view = vw;
        #1;
        check(csr_rdata == exp_read(vw), tag, csr_rdata, exp_read(vw));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        read_check(2'd0, "R1 reset full read");

        // R7: full write ignores upper bits
        cycle(3'd0, 0, 4'd0, 5'd0, 1, 2'd0, 32'hFFFF_FF6A);
        read_check(2'd0, "R7 full write upper ignored");
        // R3/R4: stored mode 3 via code 7
        cycle(3'd7, 0, 4'd0, 5'd0, 0, 2'd0, 32'h0);
        // R9: rm view write leaves flags
        cycle(3'd0, 0, 4'd0, 5'd0, 1, 2'd2, 32'hFFFF_FFF6);
        read_check(2'd1, "R9 rm write keeps flags");
        // R4: stored reserved mode 6 selected through 7
        cycle(3'd7, 0, 4'd0, 5'd0, 0, 2'd2, 32'h0);
        // R8: flags view write leaves rm
        cycle(3'd1, 0, 4'd0, 5'd0, 1, 2'd1, 32'hFFFF_FFE0);
        read_check(2'd2, "R8 flags write keeps rm");
        // R5: merge ORs, sticky
        cycle(3'd0, 1, 4'd3, 5'b00101, 0, 2'd0, 32'h0);
        cycle(3'd0, 1, 4'd10, 5'b00010, 0, 2'd0, 32'h0);
        read_check(2'd1, "R5 sticky merge");
        // R6: non-flag class ignored
        cycle(3'd0, 1, 4'd12, 5'b11000, 0, 2'd0, 32'h0);
        cycle(3'd0, 1, 4'd15, 5'b11111, 0, 2'd0, 32'h0);
        read_check(2'd1, "R6 class no effect");
        // R12: done_valid low
        cycle(3'd0, 0, 4'd0, 5'b11111, 0, 2'd0, 32'h0);
        read_check(2'd1, "R12 idle hold");
        // R11: flags write beats merge; rm write lets merge through
        cycle(3'd0, 1, 4'd1, 5'b11111, 1, 2'd1, 32'h0000_0001);
        read_check(2'd1, "R11 write wins");
        cycle(3'd0, 1, 4'd2, 5'b10000, 1, 2'd2, 32'h0000_0004);
        read_check(2'd0, "R11 rm write with merge");
        // R10: view 3 write ignored
        cycle(3'd0, 0, 4'd0, 5'd0, 1, 2'd3, 32'hFFFF_FFFF);
        read_check(2'd0, "R10 none write ignored");

        for (int i = 0; i < 400; i++) begin
            cycle(3'($urandom_range(7)), 1'($urandom_range(1)), 4'($urandom_range(15)),
                  5'($urandom_range(31)), ($urandom_range(7) == 0),
                  2'($urandom_range(3)), $urandom);
        end
        read_check(2'd0, "R5 R6 random final state");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule